// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block recovers asynchronous serial words from a single receive line. An external tick marks each sample slot, and the block is told whether a bit lasts 16 slots or 8. The line first passes through a two-stage synchronizer. When the line falls from its idle-high level, the block checks the start bit at its centre. It then takes exactly one sample at the centre of each data bit, of the optional parity bit and of the stop bit. The word length, bit order and parity mode are set by static configuration inputs and must match the sending side.

Each completed word goes into a single holding register, and a ready flag marks it as waiting. The host takes the word by pulsing a read strobe. Parity, framing and overrun problems set sticky flags, which stay set until the host pulses a clear input. A flow-control output can be enabled. When it is, the output tells the far transmitter to pause while the holding register is occupied.

Top module: `serial_frame_receiver`

## Requirements
- R1: After reset `rx_ready`, `err_parity`, `err_frame`, `err_overrun` and `rts` are 0 and `rx_data` is 0. A line held high produces no word.
- R2: With `os_sel8`=0 a bit lasts 16 `os_tick` pulses, and with `os_sel8`=1 it lasts 8. Words are received correctly at both ratios.
- R3: The start condition is a high-to-low change of the synchronized line. The line is checked again half a bit later. If it is high there, the event is dropped as a glitch and no word is produced.
- R4: `word_len` selects 5 to 9 data bits. The word is right-justified in `rx_data`, and the bits above the word length read 0.
- R5: With `msb_first`=0, the first data bit on the line is bit 0 of the word. With `msb_first`=1, the first data bit is bit `word_len`-1.
- R6: With `par_en`=1, the bit after the data is parity. Even mode (`par_odd`=0) needs an even count of ones across data and parity. Odd mode needs an odd count. A mismatch sets `err_parity`, and the word is still delivered.
- R7: A low level at the centre of the stop bit sets `err_frame`, and the word is still delivered.
- R8: If a word completes while `rx_ready` is 1 and no read is pulsed in that cycle, `err_overrun` is set. In that case `rx_data` keeps the older word and the new word is discarded.
- R9: A `rd_strobe` pulse clears `rx_ready`. The three error flags stay set until an `err_clr` pulse clears them.
- R10: With `rts_en`=1, `rts` is 1 exactly while `rx_ready` is 1. With `rts_en`=0, `rts` is 0.
- R11: `rx_ready` rises once a complete word has been written into `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse per sample slot |
| os_sel8 | input | 1 | 1: 8 slots per bit, 0: 16 slots per bit |
| word_len | input | 4 | Data bits per word, 5 to 9 |
| msb_first | input | 1 | 1: most significant data bit arrives first |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rts_en | input | 1 | Enables the flow-control output |
| rx | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Host read pulse; consumes the held word |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | 9 | Received word, right-justified |
| rx_ready | output | 1 | A word is waiting in `rx_data` |
| err_parity | output | 1 | Sticky parity mismatch flag |
| err_frame | output | 1 | Sticky stop-bit error flag |
| err_overrun | output | 1 | Sticky lost-word flag |
| rts | output | 1 | High asks the far end to pause |

## Verification
The bench targets the following corner cases:

- **Shortest and longest words in both bit orders.** A design that justified or masked the word wrongly would return shifted data or stray high bits for 5-bit and 9-bit words.
- **Short low glitch on the idle line.** A receiver that skipped the centre re-check would produce a spurious word.
- **Deliberately wrong parity bits and low stop bits.** A design that mixed up even and odd parity, or sampled the stop bit at the wrong place, would flag the wrong frames.
- **Second word arriving before a read.** This must leave the first word in place with the overrun flag set. It must also hold `rts` high until the read, and the flags must survive that read until they are explicitly cleared.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    localparam int MAX_BITS = 9;
    localparam int MIN_BITS = 5;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic             os8;
        logic [LEN_W-1:0] len;
        logic             msb_first;
        logic             par_en;
        logic             par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                par_err;
        logic                frm_err;
    } rx_word_t;

    // Keep the configured length inside the supported range.
    function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] l);
        if (int'(l) < MIN_BITS)
            return LEN_W'(MIN_BITS);
        else if (int'(l) > MAX_BITS)
            return LEN_W'(MAX_BITS);
        else
            return l;
    endfunction

    // Ones in the low l positions.
    function automatic logic [MAX_BITS-1:0] len_mask(logic [LEN_W-1:0] l);
        logic [MAX_BITS-1:0] m;
        for (int i = 0; i < MAX_BITS; i++)
            m[i] = (i < int'(l));
        return m;
    endfunction

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= rx_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], rx_in};
            end
        end
    endgenerate

    assign rx_s = pipe[STAGES-1];
endmodule

// File: rtl/ser_rx_framer.sv
module ser_rx_framer
    import ser_rx_pkg::*;
#(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  rx_cfg_t  cfg,
    output rx_word_t word,
    output logic     word_done
);
    localparam int CNT_W = $clog2(OS_HI);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [LEN_W-1:0]     bit_idx;
    logic [MAX_BITS-1:0]  shreg;
    logic                 par_acc;
    logic                 par_err_r;
    logic                 frm_err_r;
    logic                 prev_hi;

    logic [CNT_W-1:0]     full_m1;
    logic [CNT_W-1:0]     half_m1;
    logic [LEN_W-1:0]     len;
    logic [MAX_BITS-1:0]  data_c;
    logic                 at_centre;

    assign full_m1   = cfg.os8 ? CNT_W'(OS_LO - 1) : CNT_W'(OS_HI - 1);
    assign half_m1   = cfg.os8 ? CNT_W'(OS_LO / 2 - 1) : CNT_W'(OS_HI / 2 - 1);
    assign len       = clamp_len(cfg.len);
    assign at_centre = tick && (cnt == full_m1);

    // LSB-first words fill from the top and are shifted down to bit 0.
    always_comb begin
        if (cfg.msb_first)
            data_c = shreg & len_mask(len);
        else
            data_c = (shreg >> (MAX_BITS - int'(len))) & len_mask(len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_err_r <= 1'b0;
            frm_err_r <= 1'b0;
            prev_hi   <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tick) begin
                        prev_hi <= rx_s;
                        if (prev_hi && !rx_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == half_m1) begin
                            cnt <= '0;
                            if (rx_s) begin
                                state   <= ST_IDLE;
                                prev_hi <= 1'b1;
                            end else begin
                                state     <= ST_DATA;
                                bit_idx   <= '0;
                                shreg     <= '0;
                                par_acc   <= 1'b0;
                                par_err_r <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_centre) begin
                        cnt     <= '0;
                        par_acc <= par_acc ^ rx_s;
                        if (cfg.msb_first)
                            shreg <= {shreg[MAX_BITS-2:0], rx_s};
                        else
                            shreg <= {rx_s, shreg[MAX_BITS-1:1]};
                        if (bit_idx == len - 1'b1)
                            state <= cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_centre) begin
                        cnt       <= '0;
                        par_err_r <= par_acc ^ rx_s ^ cfg.par_odd;
                        state     <= ST_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_centre) begin
                        cnt       <= '0;
                        frm_err_r <= !rx_s;
                        prev_hi   <= rx_s;
                        word_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign word.data    = data_c;
    assign word.par_err = par_err_r;
    assign word.frm_err = frm_err_r;
endmodule

// File: rtl/ser_rx_hold.sv
module ser_rx_hold
    import ser_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_done,
    input  rx_word_t            word,
    input  logic                rd_strobe,
    input  logic                err_clr,
    input  logic                rts_en,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                rts
);
    logic lost;
    logic load;

    // A word arriving while the previous one is still unread is dropped.
    assign lost = word_done && rx_ready && !rd_strobe;
    assign load = word_done && !lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (load)
                rx_data <= word.data;
            rx_ready    <= load || (rx_ready && !rd_strobe);
            err_parity  <= (err_parity  && !err_clr) || (load && word.par_err);
            err_frame   <= (err_frame   && !err_clr) || (load && word.frm_err);
            err_overrun <= (err_overrun && !err_clr) || lost;
        end
    end

    assign rts = rts_en && rx_ready;
endmodule

// File: rtl/serial_frame_receiver.sv
module serial_frame_receiver
    import ser_rx_pkg::*;
#(
    parameter int OS_HI       = 16,
    parameter int OS_LO       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                os_sel8,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                msb_first,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                rts_en,
    input  logic                rx,
    input  logic                rd_strobe,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                rts
);
    logic     rx_s;
    logic     word_done;
    rx_word_t word;
    rx_cfg_t  cfg;

    assign cfg.os8       = os_sel8;
    assign cfg.len       = word_len;
    assign cfg.msb_first = msb_first;
    assign cfg.par_en    = par_en;
    assign cfg.par_odd   = par_odd;

    ser_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx),
        .rx_s  (rx_s)
    );

    ser_rx_framer #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (os_tick),
        .rx_s      (rx_s),
        .cfg       (cfg),
        .word      (word),
        .word_done (word_done)
    );

    ser_rx_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .word_done   (word_done),
        .word        (word),
        .rd_strobe   (rd_strobe),
        .err_clr     (err_clr),
        .rts_en      (rts_en),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .rts         (rts)
    );
endmodule

// File: rtl/ser_rx_checker.sv
module ser_rx_checker
    import ser_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                rts_en,
    input logic                rd_strobe,
    input logic                err_clr,
    input logic                word_done,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_ready,
    input logic                err_parity,
    input logic                err_frame,
    input logic                err_overrun,
    input logic                rts
);
    assert_ready_on_word_R11: assert property (@(posedge clk) disable iff (rst)
        word_done |=> rx_ready);

    assert_ready_needs_word_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(word_done));

    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (word_done && rx_ready && !rd_strobe) |=> (err_overrun && $stable(rx_data)));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !word_done) |=> !rx_ready);

    assert_data_held_R9: assert property (@(posedge clk) disable iff (rst)
        !word_done |=> $stable(rx_data));

    assert_perr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !err_clr) |=> err_parity);

    assert_ferr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !err_clr) |=> err_frame);

    assert_oerr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !err_clr) |=> err_overrun);

    assert_rts_only_when_full_R10: assert property (@(posedge clk) disable iff (rst)
        rts |-> (rx_ready && rts_en));

    assert_rts_when_full_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rts_en) |-> rts);
endmodule

bind serial_frame_receiver ser_rx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rts_en      (rts_en),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .word_done   (word_done),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .rts         (rts)
);

// File: tb/test_serial_frame_receiver.sv
`timescale 1ns/1ps
module test_serial_frame_receiver;

    localparam int TDIV  = 2;
    localparam int NVEC  = 12;
    localparam int WD_NS = 4 * 150000;

    // {os8, len[3:0], msb, pen, podd, flip_par, bad_stop, exp_perr, exp_ferr, data[8:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h03C},
        {1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF},
        {1'b1, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h155},
        {1'b0, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h050},
        {1'b1, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1A3},
        {1'b0, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
        {1'b0, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
        {1'b1, 4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h02D},
        {1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h081},
        {1'b1, 4'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h07F},
        {1'b0, 4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h016}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       os_sel8 = 1'b0;
    logic [3:0] word_len = 4'd8;
    logic       msb_first = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rts_en = 1'b0;
    logic       rx = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [8:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_overrun, rts;

    int checks = 0;
    int failures = 0;
    int tdiv_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        os_tick  <= (tdiv_cnt == 0);
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    end

    serial_frame_receiver i_serial_frame_receiver (
        .clk(clk), .rst(rst), .os_tick(os_tick), .os_sel8(os_sel8),
        .word_len(word_len), .msb_first(msb_first), .par_en(par_en),
        .par_odd(par_odd), .rts_en(rts_en), .rx(rx), .rd_strobe(rd_strobe),
        .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .rts(rts)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clks);
        rx = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int len, input bit msb,
                        input bit pen, input bit podd, input bit flip, input bit bad_stop);
        int bclk;
        int ones;
        logic pb;
        bclk = (os_sel8 ? 8 : 16) * TDIV;
        ones = 0;
        hold_line(1'b0, bclk);
        for (int i = 0; i < len; i++) begin
            int k;
            k = msb ? (len - 1 - i) : i;
            ones += d[k];
            hold_line(d[k], bclk);
        end
        if (pen) begin
            pb = (ones % 2 == 1) ^ podd;
            hold_line(pb ^ flip, bclk);
        end
        hold_line(!bad_stop, bclk);
        hold_line(1'b1, 2 * bclk);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(WD_NS);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [8:0] exp_d;
        rts_en = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        // R1: idle after reset
        check(rx_ready == 0, "R1 ready after reset", rx_ready, 0);
        check({err_parity, err_frame, err_overrun} == 0, "R1 flags after reset",
              {err_parity, err_frame, err_overrun}, 0);
        check(rts == 0, "R1 rts after reset", rts, 0);
        check(rx_data == 0, "R1 data after reset", rx_data, 0);
        rts_en = 1'b0;

        // Table walk: R2, R4, R5, R6, R7, R11
        for (int v = 0; v < NVEC; v++) begin
            os_sel8   = VEC[v][20];
            word_len  = VEC[v][19:16];
            msb_first = VEC[v][15];
            par_en    = VEC[v][14];
            par_odd   = VEC[v][13];
            pulse_clear();
            send(VEC[v][8:0], int'(VEC[v][19:16]), VEC[v][15], VEC[v][14], VEC[v][13],
                 VEC[v][12], VEC[v][11]);
            exp_d = VEC[v][8:0] & 9'((1 << int'(VEC[v][19:16])) - 1);
            check(rx_ready == 1, $sformatf("R11 ready vec%0d", v), rx_ready, 1);
            check(rx_data == exp_d, $sformatf("R2 R4 R5 data vec%0d", v), rx_data, exp_d);
            check(err_parity == VEC[v][10], $sformatf("R6 parity flag vec%0d", v),
                  err_parity, VEC[v][10]);
            check(err_frame == VEC[v][9], $sformatf("R7 frame flag vec%0d", v),
                  err_frame, VEC[v][9]);
            check(err_overrun == 0, $sformatf("R8 no overrun vec%0d", v), err_overrun, 0);
            check(rts == 0, $sformatf("R10 rts disabled vec%0d", v), rts, 0);
            pulse_read();
            check(rx_ready == 0, $sformatf("R9 read clears vec%0d", v), rx_ready, 0);
            if (VEC[v][10] || VEC[v][9])
                check(err_parity == VEC[v][10] && err_frame == VEC[v][9],
                      $sformatf("R9 flags sticky after read vec%0d", v),
                      {err_parity, err_frame}, {VEC[v][10], VEC[v][9]});
        end

        // R3: short low glitch must not start a word
        os_sel8 = 1'b0; word_len = 4'd8; msb_first = 1'b0; par_en = 1'b0;
        pulse_clear();
        hold_line(1'b0, 8);
        hold_line(1'b1, 3 * 16 * TDIV);
        check(rx_ready == 0, "R3 glitch ignored ready", rx_ready, 0);
        check(err_frame == 0, "R3 glitch ignored frame", err_frame, 0);
        send(9'h0C3, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rx_ready == 1 && rx_data == 9'h0C3, "R3 word after glitch", rx_data, 9'h0C3);
        pulse_read();

        // R8 and R10: overrun with flow control on
        rts_en = 1'b1;
        @(negedge clk);
        check(rts == 0, "R10 rts low when empty", rts, 0);
        send(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rts == 1, "R10 rts high when full", rts, 1);
        send(9'h022, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(err_overrun == 1, "R8 overrun flag", err_overrun, 1);
        check(rx_data == 9'h011, "R8 older word kept", rx_data, 9'h011);
        check(rx_ready == 1, "R8 still ready", rx_ready, 1);
        pulse_read();
        check(rx_ready == 0, "R9 ready cleared", rx_ready, 0);
        check(rts == 0, "R10 rts low after read", rts, 0);
        check(err_overrun == 1, "R9 overrun sticky", err_overrun, 1);
        pulse_clear();
        check(err_overrun == 0, "R9 clear drops overrun", err_overrun, 0);

        // R10: disabled flow control stays low with a word waiting
        rts_en = 1'b0;
        send(9'h05A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rx_ready == 1, "R11 ready set", rx_ready, 1);
        check(rts == 0, "R10 rts off while full", rts, 0);
        pulse_read();

        // R1: line held high yields nothing
        hold_line(1'b1, 400);
        check(rx_ready == 0, "R1 idle line no word", rx_ready, 0);

        finish_run();
    end
endmodule